// File: doc/BRIEF.md
# GPIO Alternate-Function Pin Multiplexer

This block sits between the on-chip peripherals and the pads of three 8-bit general-purpose ports, 24 pins in all. For every pin it decides which signal drives the pad and in which electrical mode. It produces a driven value, an output enable, an open-drain flag, a pull-up request and a pull-down request. The choice comes from a per-pin 4-bit mode code held in a small register file. Alternate-function pins take their value from a fixed source ladder. An enabled timer channel routed to the pin comes first, then a serial controller that owns the pin, then the trace sources on the two trace pins. A pin with none of these drives zero.

Some pins have functions forced on them that ignore the mode code. The debug interface takes over four pins of port C while it is active, unless a release bit hands them back. A regulator-force bit turns pin 7 of port A into an open-drain output of the regulator enable. All outputs are combinational from the registers and the peripheral inputs. Every interface is a plain level signal. There is no streaming data path, so no valid/ready handshake exists and no back-pressure applies.

Pins are numbered p = 8*port + bit. Port A is pins 0..7, port B is pins 8..15 and port C is pins 16..23.

Top module: `pinmux_top`

## Requirements
- R1: After reset every register reads 0 at every address. With the debug inputs low, every pin has pin_out, pin_oe, pin_od, pin_pu and pin_pd at 0.
- R2: A write with wr_en high takes effect at the next rising clock edge, and rd_data shows the register selected by rd_addr combinationally. The register map is as follows:
  - Address a in 0..11 holds the mode of pin 2a in bits [3:0] and the mode of pin 2a+1 in bits [7:4].
  - Addresses 12..14 hold the GPIO output values of ports A..C, where bit b belongs to pin b of that port.
  - Address 15 bits [3:0] hold the timer route bits, where bit c belongs to channel c.
  - Address 16 bit 0 is the debug release, bit 1 is the regulator force and bit 2 is the trace select.
  - Other bits and addresses read 0 and ignore writes.
- R3: The mode codes are as follows:
  - 0: floating input (nothing asserted).
  - 1: input with pu.
  - 2: input with pd.
  - 3: push-pull GPIO output (oe=1, out=data bit).
  - 4: open-drain GPIO output.
  - 5: alternate push-pull.
  - 6: alternate open-drain.
  - Codes 7..15 behave as code 0.
  - pu and pd are never both asserted.
- R4: In both open-drain modes od=1, out equals the selected value, and oe is 1 only when that value is 0. An open-drain pin never has od, oe and out all high.
- R5: Timer channel c (0..3) goes to a port A pin when route bit c is 0 and to a port B pin when it is 1:
  - channel 0: pin 0 or pin 9;
  - channel 1: pin 3 or pin 10;
  - channel 2: pin 1 or pin 11;
  - channel 3: pin 2 or pin 12.
- R6: A timer channel drives its routed pin only while tmr_oc_en[c] is 1. Otherwise the pin falls to the next source.
- R7: An enabled timer channel overrides a serial output on the same pin. A pin with ser_own[p]=1 and no enabled timer channel takes ser_out[p] as its alternate value.
- R8: A pin in an alternate mode with no timer, serial or trace source drives value 0.
- R9: Pins 4 and 5 (port A bits 4, 5), when not owned by serial or timer, take their alternate value from the trace sources:
  - with trace select 0: pkt_trace_en and pkt_trace_data;
  - with trace select 1: cpu_trace[0] and cpu_trace[1].
- R10: With jtag_active=1 and release=0, four port C pins are forced:
  - pin 16 is an input with pu;
  - pin 18 is a push-pull output of jtag_tdo;
  - pin 19 is an input with pu;
  - pin 20 is an input with pu.
- R11: With swd_active=1 and release=0, pin 20 has out=swd_dout, oe=swd_drive, and od, pu and pd at 0. This takes priority over R10 on pin 20.
- R12: With release=1, pins 16, 18, 19 and 20 follow their mode codes whatever the debug inputs are.
- R13: With regulator force=1, pin 7 is open-drain with out=regulator_en, oe=!regulator_en and no pull, regardless of its mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| tmr_oc | input | 4 | Timer compare output values, one per channel |
| tmr_oc_en | input | 4 | Timer compare output enables |
| ser_out | input | 24 | Serial controller output value per pin |
| ser_own | input | 24 | Serial controller claims the pin |
| pkt_trace_en | input | 1 | Packet trace enable source |
| pkt_trace_data | input | 1 | Packet trace data source |
| cpu_trace | input | 2 | CPU trace data bits |
| jtag_active | input | 1 | Debugger active in four-wire mode |
| swd_active | input | 1 | Debugger active in two-wire mode |
| swd_drive | input | 1 | Two-wire data direction, 1 = drive |
| swd_dout | input | 1 | Two-wire data value |
| jtag_tdo | input | 1 | Test data out value |
| regulator_en | input | 1 | Regulator enable value |
| pin_out | output | 24 | Driven value per pin |
| pin_oe | output | 24 | Output enable per pin |
| pin_od | output | 24 | Open-drain flag per pin |
| pin_pu | output | 24 | Pull-up request per pin |
| pin_pd | output | 24 | Pull-down request per pin |

## Verification
The bench concentrates on the source ladder and the routing. A wrong route bit or a wrong stored enable moves a timer value onto the wrong pin, and the serial pattern shows up where the timer value should be. Because every output is combinational from the registers, such a fault is visible at the pads in the cycle right after the offending write. A corrupted mode nibble or release bit shows in that same cycle as a wrong enable or pull on one pin, and it also reads back wrong through rd_data. The sweeps cover every mode code, every route/enable combination and every debug input combination, so any single stuck state bit changes at least one pad output.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int CW = 4;

  typedef enum logic [3:0] {
    MODE_IN_FLOAT = 4'd0,
    MODE_IN_PU    = 4'd1,
    MODE_IN_PD    = 4'd2,
    MODE_OUT_PP   = 4'd3,
    MODE_OUT_OD   = 4'd4,
    MODE_ALT_PP   = 4'd5,
    MODE_ALT_OD   = 4'd6
  } pin_mode_e;

  typedef struct packed {
    logic drv;
    logic oe;
    logic od;
    logic pu;
    logic pd;
  } pad_t;

  localparam pad_t PAD_IDLE = '0;

  // fixed pin positions that peripherals decode
  localparam int PIN_TRACE0  = 4;
  localparam int PIN_TRACE1  = 5;
  localparam int PIN_VREG    = 7;
  localparam int PIN_DBG_RST = 16;
  localparam int PIN_DBG_DO  = 18;
  localparam int PIN_DBG_DI  = 19;
  localparam int PIN_DBG_MS  = 20;

  // destination pin of a timer channel for a given route bit
  function automatic int tmr_pin(input int ch, input logic to_b);
    case (ch)
      0:       tmr_pin = to_b ? 9  : 0;
      1:       tmr_pin = to_b ? 10 : 3;
      2:       tmr_pin = to_b ? 11 : 1;
      default: tmr_pin = to_b ? 12 : 2;
    endcase
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs import pinmux_pkg::*; #(
  parameter int NPORT = 3,
  parameter int PW    = 8,
  parameter int NCH   = 4,
  parameter int AW    = 5,
  parameter int NCTL  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [PW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [PW-1:0]         rd_data,
  output logic [NPORT*PW*CW-1:0] cfg_q,
  output logic [NPORT*PW-1:0]   dat_q,
  output logic [NCH-1:0]        route_q,
  output logic [NCTL-1:0]       ctl_q
);
  localparam int NPIN       = NPORT * PW;
  localparam int NCFG_ADDR  = (NPIN * CW) / PW;
  localparam int ADDR_DAT   = NCFG_ADDR;
  localparam int ADDR_ROUTE = ADDR_DAT + NPORT;
  localparam int ADDR_CTL   = ADDR_ROUTE + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      dat_q   <= '0;
      route_q <= '0;
      ctl_q   <= '0;
    end else if (wr_en) begin
      for (int a = 0; a < NCFG_ADDR; a++)
        if (wr_addr == AW'(a)) cfg_q[a*PW +: PW] <= wr_data;
      for (int k = 0; k < NPORT; k++)
        if (wr_addr == AW'(ADDR_DAT + k)) dat_q[k*PW +: PW] <= wr_data;
      if (wr_addr == AW'(ADDR_ROUTE)) route_q <= wr_data[NCH-1:0];
      if (wr_addr == AW'(ADDR_CTL))   ctl_q   <= wr_data[NCTL-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int a = 0; a < NCFG_ADDR; a++)
      if (rd_addr == AW'(a)) rd_data = cfg_q[a*PW +: PW];
    for (int k = 0; k < NPORT; k++)
      if (rd_addr == AW'(ADDR_DAT + k)) rd_data = dat_q[k*PW +: PW];
    if (rd_addr == AW'(ADDR_ROUTE)) rd_data = PW'(route_q);
    if (rd_addr == AW'(ADDR_CTL))   rd_data = PW'(ctl_q);
  end
endmodule

// File: rtl/pinmux_altsrc.sv
module pinmux_altsrc import pinmux_pkg::*; #(
  parameter int NPIN = 24,
  parameter int NCH  = 4
) (
  input  logic [NCH-1:0]  tmr_oc,
  input  logic [NCH-1:0]  tmr_oc_en,
  input  logic [NCH-1:0]  route,
  input  logic [NPIN-1:0] ser_out,
  input  logic [NPIN-1:0] ser_own,
  input  logic            trace_sel,
  input  logic            pkt_trace_en,
  input  logic            pkt_trace_data,
  input  logic [1:0]      cpu_trace,
  output logic [NPIN-1:0] alt_val
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic tmr_hit;
    logic tmr_val;
    logic trc_val;

    always_comb begin
      tmr_hit = 1'b0;
      tmr_val = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (tmr_oc_en[c] && (tmr_pin(c, route[c]) == p)) begin
          tmr_hit = 1'b1;
          tmr_val = tmr_oc[c];
        end
      end
    end

    if (p == PIN_TRACE0) begin : g_trc0
      assign trc_val = trace_sel ? cpu_trace[0] : pkt_trace_en;
    end else if (p == PIN_TRACE1) begin : g_trc1
      assign trc_val = trace_sel ? cpu_trace[1] : pkt_trace_data;
    end else begin : g_notrc
      assign trc_val = 1'b0;
    end

    // ladder: timer, then serial, then trace, else zero
    assign alt_val[p] = tmr_hit    ? tmr_val :
                        ser_own[p] ? ser_out[p] : trc_val;
  end
endmodule

// File: rtl/pinmux_pad_mode.sv
module pinmux_pad_mode import pinmux_pkg::*; (
  input  logic [CW-1:0] mode,
  input  logic          gpio_val,
  input  logic          alt_val,
  output pad_t          pad
);
  always_comb begin
    pad = PAD_IDLE;
    case (mode)
      MODE_IN_PU: pad.pu = 1'b1;
      MODE_IN_PD: pad.pd = 1'b1;
      MODE_OUT_PP: begin
        pad.drv = gpio_val;
        pad.oe  = 1'b1;
      end
      MODE_OUT_OD: begin
        pad.drv = gpio_val;
        pad.oe  = ~gpio_val;
        pad.od  = 1'b1;
      end
      MODE_ALT_PP: begin
        pad.drv = alt_val;
        pad.oe  = 1'b1;
      end
      MODE_ALT_OD: begin
        pad.drv = alt_val;
        pad.oe  = ~alt_val;
        pad.od  = 1'b1;
      end
      default: pad = PAD_IDLE;
    endcase
  end
endmodule

// File: rtl/pinmux_force.sv
module pinmux_force import pinmux_pkg::*; #(
  parameter int NPIN = 24
) (
  input  pad_t base [NPIN],
  input  logic dbg_release,
  input  logic vreg_force,
  input  logic jtag_active,
  input  logic swd_active,
  input  logic swd_drive,
  input  logic swd_dout,
  input  logic jtag_tdo,
  input  logic regulator_en,
  output pad_t fin  [NPIN]
);
  pad_t in_pu;
  assign in_pu = '{drv: 1'b0, oe: 1'b0, od: 1'b0, pu: 1'b1, pd: 1'b0};

  always_comb begin
    fin = base;
    if (vreg_force) begin
      fin[PIN_VREG] = '{drv: regulator_en, oe: ~regulator_en, od: 1'b1, pu: 1'b0, pd: 1'b0};
    end
    if (!dbg_release && jtag_active) begin
      fin[PIN_DBG_RST] = in_pu;
      fin[PIN_DBG_DO]  = '{drv: jtag_tdo, oe: 1'b1, od: 1'b0, pu: 1'b0, pd: 1'b0};
      fin[PIN_DBG_DI]  = in_pu;
      fin[PIN_DBG_MS]  = in_pu;
    end
    if (!dbg_release && swd_active) begin
      fin[PIN_DBG_MS] = '{drv: swd_dout, oe: swd_drive, od: 1'b0, pu: 1'b0, pd: 1'b0};
    end
  end
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top import pinmux_pkg::*; #(
  parameter int NPORT = 3,
  parameter int PW    = 8,
  parameter int NCH   = 4,
  parameter int AW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [PW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [PW-1:0]         rd_data,
  input  logic [NCH-1:0]        tmr_oc,
  input  logic [NCH-1:0]        tmr_oc_en,
  input  logic [NPORT*PW-1:0]   ser_out,
  input  logic [NPORT*PW-1:0]   ser_own,
  input  logic                  pkt_trace_en,
  input  logic                  pkt_trace_data,
  input  logic [1:0]            cpu_trace,
  input  logic                  jtag_active,
  input  logic                  swd_active,
  input  logic                  swd_drive,
  input  logic                  swd_dout,
  input  logic                  jtag_tdo,
  input  logic                  regulator_en,
  output logic [NPORT*PW-1:0]   pin_out,
  output logic [NPORT*PW-1:0]   pin_oe,
  output logic [NPORT*PW-1:0]   pin_od,
  output logic [NPORT*PW-1:0]   pin_pu,
  output logic [NPORT*PW-1:0]   pin_pd
);
  localparam int NPIN = NPORT * PW;
  localparam int NCTL = 3;

  logic [NPIN*CW-1:0] cfg_w;
  logic [NPIN-1:0]    dat_w;
  logic [NCH-1:0]     route_w;
  logic [NCTL-1:0]    ctl_w;
  logic [NPIN-1:0]    alt_w;
  pad_t               base_w [NPIN];
  pad_t               fin_w  [NPIN];

  pinmux_regs #(.NPORT(NPORT), .PW(PW), .NCH(NCH), .AW(AW), .NCTL(NCTL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_q(cfg_w), .dat_q(dat_w), .route_q(route_w), .ctl_q(ctl_w)
  );

  pinmux_altsrc #(.NPIN(NPIN), .NCH(NCH)) u_alt (
    .tmr_oc(tmr_oc), .tmr_oc_en(tmr_oc_en), .route(route_w),
    .ser_out(ser_out), .ser_own(ser_own), .trace_sel(ctl_w[2]),
    .pkt_trace_en(pkt_trace_en), .pkt_trace_data(pkt_trace_data),
    .cpu_trace(cpu_trace), .alt_val(alt_w)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pad
    pinmux_pad_mode u_mode (
      .mode(cfg_w[p*CW +: CW]), .gpio_val(dat_w[p]), .alt_val(alt_w[p]), .pad(base_w[p])
    );
    assign pin_out[p] = fin_w[p].drv;
    assign pin_oe[p]  = fin_w[p].oe;
    assign pin_od[p]  = fin_w[p].od;
    assign pin_pu[p]  = fin_w[p].pu;
    assign pin_pd[p]  = fin_w[p].pd;
  end

  pinmux_force #(.NPIN(NPIN)) u_force (
    .base(base_w), .dbg_release(ctl_w[0]), .vreg_force(ctl_w[1]),
    .jtag_active(jtag_active), .swd_active(swd_active), .swd_drive(swd_drive),
    .swd_dout(swd_dout), .jtag_tdo(jtag_tdo), .regulator_en(regulator_en),
    .fin(fin_w)
  );
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
  parameter int NPIN = 24,
  parameter int NCH  = 4,
  parameter int AW   = 5,
  parameter int PW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [PW-1:0]   wr_data,
  input logic [NCH-1:0]  route_w,
  input logic [2:0]      ctl_w,
  input logic            jtag_active,
  input logic            swd_active,
  input logic            swd_drive,
  input logic            swd_dout,
  input logic            jtag_tdo,
  input logic            regulator_en,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] pin_od,
  input logic [NPIN-1:0] pin_pu,
  input logic [NPIN-1:0] pin_pd
);
  // R2
  route_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(15)) |=> (route_w == $past(wr_data[NCH-1:0])));

  // R3
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_pd) == '0));

  // R4
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & pin_oe & pin_out) == '0));

  // R10
  jtag_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (jtag_active && !swd_active && !ctl_w[0]) |->
      (pin_oe[18] && pin_out[18] == jtag_tdo && pin_pu[16] && !pin_oe[16] && pin_pu[19]));

  // R11
  swd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swd_active && !ctl_w[0]) |->
      (pin_oe[20] == swd_drive && pin_out[20] == swd_dout && !pin_pu[20] && !pin_od[20]));

  // R13
  vreg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w[1] |-> (pin_od[7] && pin_oe[7] == !regulator_en && pin_out[7] == regulator_en));
endmodule

bind pinmux_top pinmux_chk #(.NPIN(NPIN), .NCH(NCH), .AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .route_w(route_w), .ctl_w(ctl_w), .jtag_active(jtag_active), .swd_active(swd_active),
  .swd_drive(swd_drive), .swd_dout(swd_dout), .jtag_tdo(jtag_tdo), .regulator_en(regulator_en),
  .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd)
);

// File: tb/sim_pinmux_top.sv
module sim_pinmux_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [3:0]  tmr_oc = '0, tmr_oc_en = '0;
  logic [23:0] ser_out = '0, ser_own = '0;
  logic        pkt_trace_en = 1'b0, pkt_trace_data = 1'b0;
  logic [1:0]  cpu_trace = '0;
  logic        jtag_active = 1'b0, swd_active = 1'b0, swd_drive = 1'b0, swd_dout = 1'b0;
  logic        jtag_tdo = 1'b0, regulator_en = 1'b0;
  logic [23:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;

  pinmux_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_oc(tmr_oc), .tmr_oc_en(tmr_oc_en),
    .ser_out(ser_out), .ser_own(ser_own), .pkt_trace_en(pkt_trace_en),
    .pkt_trace_data(pkt_trace_data), .cpu_trace(cpu_trace), .jtag_active(jtag_active),
    .swd_active(swd_active), .swd_drive(swd_drive), .swd_dout(swd_dout),
    .jtag_tdo(jtag_tdo), .regulator_en(regulator_en), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_od(pin_od), .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  // bench-side model state
  logic [3:0]  m_cfg [24];
  logic [23:0] m_dat = '0;
  logic [3:0]  m_route = '0;
  logic [2:0]  m_ctl = '0;
  int nchk = 0, nerr = 0;
  bit ended = 0;

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 12) begin m_cfg[2*a] = d[3:0]; m_cfg[2*a+1] = d[7:4]; end
    else if (a < 15) m_dat[(a-12)*8 +: 8] = d;
    else if (a == 15) m_route = d[3:0];
    else if (a == 16) m_ctl = d[2:0];
  endtask

  task automatic all_modes(input logic [3:0] code);
    for (int a = 0; a < 12; a++) wr(a, {code, code});
  endtask

  function automatic int tpin(input int c, input logic b);
    int pa;
    pa = (c == 0) ? 0 : (c == 1) ? 3 : (c == 2) ? 1 : 2;
    return b ? (9 + c) : pa;
  endfunction

  task automatic predict(output logic [23:0] eo, eoe, eod, epu, epd);
    for (int p = 0; p < 24; p++) begin
      logic av, hit, o, e, d, u, n;
      av = 1'b0; hit = 1'b0;
      for (int c = 0; c < 4; c++)
        if (tmr_oc_en[c] && tpin(c, m_route[c]) == p) begin hit = 1'b1; av = tmr_oc[c]; end
      if (!hit && ser_own[p]) begin hit = 1'b1; av = ser_out[p]; end
      if (!hit && p == 4) av = m_ctl[2] ? cpu_trace[0] : pkt_trace_en;
      if (!hit && p == 5) av = m_ctl[2] ? cpu_trace[1] : pkt_trace_data;
      o = 0; e = 0; d = 0; u = 0; n = 0;
      case (m_cfg[p])
        4'd1: u = 1;
        4'd2: n = 1;
        4'd3: begin o = m_dat[p]; e = 1; end
        4'd4: begin o = m_dat[p]; e = !m_dat[p]; d = 1; end
        4'd5: begin o = av; e = 1; end
        4'd6: begin o = av; e = !av; d = 1; end
        default: ;
      endcase
      if (p == 7 && m_ctl[1]) begin o = regulator_en; e = !regulator_en; d = 1; u = 0; n = 0; end
      if (!m_ctl[0] && jtag_active && (p == 16 || p == 19 || p == 20)) begin
        o = 0; e = 0; d = 0; u = 1; n = 0;
      end
      if (!m_ctl[0] && jtag_active && p == 18) begin o = jtag_tdo; e = 1; d = 0; u = 0; n = 0; end
      if (!m_ctl[0] && swd_active && p == 20) begin
        o = swd_dout; e = swd_drive; d = 0; u = 0; n = 0;
      end
      eo[p] = o; eoe[p] = e; eod[p] = d; epu[p] = u; epd[p] = n;
    end
  endtask

  task automatic chk(input string tag);
    logic [23:0] eo, eoe, eod, epu, epd;
    @(negedge clk); #1;
    predict(eo, eoe, eod, epu, epd);
    nchk++;
    if (pin_out !== eo || pin_oe !== eoe || pin_od !== eod || pin_pu !== epu || pin_pd !== epd) begin
      nerr++;
      $display("FAIL %s: out/oe/od/pu/pd got %h/%h/%h/%h/%h expected %h/%h/%h/%h/%h",
               tag, pin_out, pin_oe, pin_od, pin_pu, pin_pd, eo, eoe, eod, epu, epd);
    end
  endtask

  task automatic chk_rd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = 5'(a);
    #1;
    nchk++;
    if (rd_data !== exp) begin
      nerr++;
      $display("FAIL %s: rd_data[%0d] got %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] pats [4];
    logic [3:0] ocs [3];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    ocs  = '{4'b0101, 4'b1010, 4'b1111};
    for (int p = 0; p < 24; p++) m_cfg[p] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 reset pads");
    for (int a = 0; a < 32; a++) chk_rd(a, 8'h00, "R1 reset readback");

    // R2 register write/read and reserved bits
    for (int a = 0; a < 32; a++) wr(a, 8'(8'h93 + 8'(a * 37)));
    for (int a = 0; a < 32; a++) begin
      logic [7:0] v;
      v = 8'(8'h93 + 8'(a * 37));
      chk_rd(a, (a < 15) ? v : (a == 15) ? {4'h0, v[3:0]} : (a == 16) ? {5'h0, v[2:0]} : 8'h00,
             "R2 readback");
    end
    wr(15, 8'h00); wr(16, 8'h00);

    // R3 R4 R8 every mode code against several GPIO data patterns, no alternate source
    for (int code = 0; code < 16; code++) begin
      all_modes(4'(code));
      for (int i = 0; i < 4; i++) begin
        wr(12, pats[i]); wr(13, pats[(i+1)%4]); wr(14, pats[(i+2)%4]);
        chk("R3 R4 R8 mode sweep");
      end
    end

    // R5 R6 R7 timer routing, enable and priority over serial
    all_modes(4'd5);
    ser_own = 24'hFFFFFF; ser_out = 24'h5A3C96;
    for (int r = 0; r < 16; r++) begin
      wr(15, 8'(r));
      for (int en = 0; en < 16; en++)
        for (int i = 0; i < 3; i++) begin
          tmr_oc_en = 4'(en); tmr_oc = ocs[i];
          chk("R5 R6 R7 timer route");
        end
    end
    // R6 R8 timer enable with no serial owner
    ser_own = 24'h000000;
    for (int r = 0; r < 16; r += 5) begin
      wr(15, 8'(r));
      for (int en = 0; en < 16; en++) begin
        tmr_oc_en = 4'(en); tmr_oc = 4'hF;
        chk("R6 R8 timer gating");
      end
    end
    // R4 R7 alternate open-drain with serial sources
    all_modes(4'd6);
    tmr_oc_en = 4'h0;
    for (int i = 0; i < 4; i++) begin
      ser_own = {3{pats[i]}}; ser_out = {pats[(i+1)%4], pats[(i+2)%4], pats[(i+3)%4]};
      chk("R4 R7 alt open-drain");
    end

    // R9 trace select on pins 4 and 5
    all_modes(4'd5);
    ser_out = 24'h000030;
    for (int s = 0; s < 2; s++) begin
      wr(16, 8'(s << 2));
      for (int v = 0; v < 16; v++)
        for (int o = 0; o < 4; o++) begin
          {pkt_trace_en, pkt_trace_data, cpu_trace} = 4'(v);
          ser_own = 24'(o << 4);
          chk("R9 trace select");
        end
    end
    wr(16, 8'h00);
    ser_own = 24'h0; pkt_trace_en = 0; pkt_trace_data = 0; cpu_trace = 0;

    // R10 R11 R12 debug forcing and release
    all_modes(4'd3);
    wr(12, 8'hA5); wr(13, 8'h5A); wr(14, 8'hFF);
    for (int v = 0; v < 64; v++) begin
      if (v[5] != m_ctl[0]) wr(16, {7'h0, v[5]});
      {jtag_active, swd_active, swd_drive, swd_dout, jtag_tdo} = 5'(v);
      chk("R10 R11 R12 debug force");
    end
    wr(14, 8'h00);
    all_modes(4'd2);
    for (int v = 0; v < 8; v++) begin
      {jtag_active, swd_active, jtag_tdo} = 3'(v);
      chk("R10 R11 R12 debug over pull-down");
    end
    jtag_active = 0; swd_active = 0; wr(16, 8'h00);

    // R13 regulator force on pin 7
    for (int m = 0; m < 4; m++) begin
      wr(3, {((m == 0) ? 4'd0 : (m == 1) ? 4'd1 : (m == 2) ? 4'd3 : 4'd5), 4'd0});
      wr(12, 8'h80);
      for (int v = 0; v < 4; v++) begin
        if (v[1] != m_ctl[1]) wr(16, {6'h0, v[1], 1'b0});
        regulator_en = v[0];
        chk("R13 regulator force");
      end
    end

    summary();
  end
endmodule